// File: doc/BRIEF.md
# Two-Wire Target with Register Pointer

This block is the target side of a two-wire SMBus/I2C link for a register-mapped peripheral. It watches oversampled SCL and SDA lines, removes short glitches, detects START and STOP, and answers a 7-bit device address. The five upper address bits are fixed. The two lower bits come from a three-level strap, which is latched once after reset.

A write transfer loads an internal register pointer from its first data byte. An optional second byte is then written to the register the pointer selects, using a one-cycle write strobe on a simple register port. A read transfer returns exactly one byte, MSB first, taken from the register the stored pointer selects. A read and a write cannot share one transfer, so a repeated START is used to set the pointer and then read. The block drives SDA only through a pull-down enable.

The controlling state machine has these states: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_PTR`, `ST_PTR_ACK`, `ST_DATA`, `ST_DATA_ACK`, `ST_TX`, `ST_TX_ACK` and `ST_IGNORE`.

- Any START moves the machine to `ST_ADDR`. Any STOP moves it to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` on an address match and to `ST_IGNORE` otherwise.
- From `ST_ADDR_ACK`, the machine goes to `ST_TX` for a read or to `ST_PTR` for a write.
- On a write, the path is `ST_PTR`, `ST_PTR_ACK`, `ST_DATA`, `ST_DATA_ACK`, then `ST_IGNORE`.
- On a read, the path is `ST_TX`, `ST_TX_ACK`, then `ST_IGNORE`.

Top module: `smb_ptr_target`

## Requirements
- R1: The device address is {5'b01011, A1, A0}. An address byte matching it is acknowledged by SDA pulled low for the whole ninth SCL clock. The R/W bit is the byte's LSB, with 1 meaning read.
- R2: strap_i encodes the strap level: 2'b00 tied low gives A1A0=10, 2'b01 open gives 00, 2'b10 tied high gives 01, and 2'b11 is treated as open. With the strap open, the device answers 0x2C.
- R3: The strap is sampled only in the first clock after reset. Later changes of strap_i leave the device address unchanged.
- R4: The first data byte of a write loads the pointer, which appears on reg_addr_o. That byte is acknowledged. The pointer is 0 after reset.
- R5: A second data byte in a write is acknowledged and gives exactly one reg_we_o pulse of one cycle. During that pulse, reg_wdata_o carries the byte and reg_addr_o carries the pointer.
- R6: Bytes after the second data byte of a write are not acknowledged and cause no write.
- R7: A read transfer shifts out reg_rdata_i for the current pointer, MSB first. The pointer is left unchanged and is not written.
- R8: sda_pd_o changes only while filtered SCL is low, or when a START or STOP resets it.
- R9: If the address does not match, no acknowledge is given and nothing is written. Following bytes are ignored until the next START.
- R10: A repeated START ends the current transfer and restarts address decoding. The pointer keeps its value.
- R11: A pulse on SCL or SDA shorter than FILT_CYC clock cycles (default 12 cycles, 60 ns at 200 MHz) has no effect on the transfer.
- R12: A STOP returns the block to idle and releases SDA. Clock pulses without a preceding START are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| strap_i | input | 2 | Three-level strap sense code for the low address bits |
| sda_pd_o | output | 1 | SDA pull-down enable (1 drives the line low) |
| reg_addr_o | output | 8 | Register pointer, used as the register address |
| reg_wdata_o | output | 8 | Write data for the register port |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_rdata_i | input | 8 | Read data of the register at reg_addr_o |

## Verification
The bound checker checks several rules on every cycle:
- The write strobe is a single pulse, and it comes only from the data-byte state.
- SDA is released in the ignore state.
- The pull-down changes only during SCL low.
- START and STOP force the address-decode and idle states.
- The latched address bits stay fixed once sampled.

Other behaviour needs whole bus scenarios in the bench:
- address matching for each strap level;
- pointer loading;
- byte-count limits;
- read data order;
- pointer retention across a repeated START;
- glitch rejection, which the bench shows by the correct final register contents.

// File: rtl/smb_tgt_pkg.sv
package smb_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } smb_state_e;

    localparam logic [1:0] STRAP_LOW  = 2'b00;
    localparam logic [1:0] STRAP_OPEN = 2'b01;
    localparam logic [1:0] STRAP_HIGH = 2'b10;

    // map the sensed strap level to the two low address bits
    function automatic logic [1:0] strap_to_lo(input logic [1:0] lvl);
        logic [1:0] lo;
        unique case (lvl)
            STRAP_LOW:  lo = 2'b10;
            STRAP_HIGH: lo = 2'b01;
            default:    lo = 2'b00;
        endcase
        return lo;
    endfunction

endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
    parameter int FILT_CYC = 12,
    parameter bit RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic flt_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= {2{RST_VAL}};
            run_q  <= '0;
            flt_o  <= RST_VAL;
        end else begin
            sync_q <= {sync_q[0], raw_i};
            if (sync_q[1] == flt_o) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_CYC - 1)) begin
                flt_o <= sync_q[1];
                run_q <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smb_bus_events.sv
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f_i;
            sda_q <= sda_f_i;
        end
    end

    always_comb begin
        scl_rise_o = scl_f_i & ~scl_q;
        scl_fall_o = ~scl_f_i & scl_q;
        start_o    = scl_f_i & scl_q & sda_q & ~sda_f_i;
        stop_o     = scl_f_i & scl_q & ~sda_q & sda_f_i;
    end
endmodule

// File: rtl/smb_target_fsm.sv
module smb_target_fsm
    import smb_tgt_pkg::*;
#(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_rise_i,
    input  logic          scl_fall_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          sda_f_i,
    input  logic [AW-1:0] dev_addr_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] ptr_o,
    output logic [DW-1:0] wdata_o,
    output logic          we_o,
    output logic          sda_pd_o,
    output smb_state_e    state_o
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] BYTE_END = CW'(DW);
    localparam logic [CW-1:0] TX_LAST  = CW'(DW - 1);

    smb_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [DW-1:0] shift_q;
    logic          byte_done;
    logic          addr_hit;
    logic          is_read;

    assign byte_done = scl_fall_i && (cnt_q == BYTE_END);
    assign addr_hit  = (shift_q[DW-1:1] == dev_addr_i);
    assign is_read   = shift_q[0];
    assign state_o   = state_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     state_d = ST_IDLE;
            ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
            ST_ADDR_ACK: if (scl_fall_i) state_d = is_read ? ST_TX : ST_PTR;
            ST_PTR:      if (byte_done) state_d = ST_PTR_ACK;
            ST_PTR_ACK:  if (scl_fall_i) state_d = ST_DATA;
            ST_DATA:     if (byte_done) state_d = ST_DATA_ACK;
            ST_DATA_ACK: if (scl_fall_i) state_d = ST_IGNORE;
            ST_TX:       if (scl_fall_i && cnt_q == TX_LAST) state_d = ST_TX_ACK;
            ST_TX_ACK:   if (scl_fall_i) state_d = ST_IGNORE;
            ST_IGNORE:   state_d = ST_IGNORE;
            default:     state_d = ST_IDLE;
        endcase
        if (start_i) begin
            state_d = ST_ADDR;
        end else if (stop_i) begin
            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // bit counter, shifter and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
            ptr_o   <= '0;
        end else if (start_i) begin
            cnt_q   <= '0;
            shift_q <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_PTR, ST_DATA: begin
                    if (scl_rise_i && cnt_q != BYTE_END) begin
                        shift_q <= {shift_q[DW-2:0], sda_f_i};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                    if (state_q == ST_PTR && byte_done) ptr_o <= shift_q;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall_i) begin
                        cnt_q <= '0;
                        if (is_read) shift_q <= rdata_i;
                    end
                end
                ST_PTR_ACK: if (scl_fall_i) cnt_q <= '0;
                ST_TX: begin
                    if (scl_fall_i && cnt_q != TX_LAST) begin
                        shift_q <= {shift_q[DW-2:0], 1'b0};
                        cnt_q   <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs: pull-down and register write port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pd_o <= 1'b0;
            we_o     <= 1'b0;
            wdata_o  <= '0;
        end else begin
            we_o <= 1'b0;
            if (start_i || stop_i) begin
                sda_pd_o <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_ADDR:     if (byte_done) sda_pd_o <= addr_hit;
                    ST_PTR:      if (byte_done) sda_pd_o <= 1'b1;
                    ST_DATA: begin
                        if (byte_done) begin
                            sda_pd_o <= 1'b1;
                            we_o     <= 1'b1;
                            wdata_o  <= shift_q;
                        end
                    end
                    ST_ADDR_ACK: if (scl_fall_i) sda_pd_o <= is_read ? ~rdata_i[DW-1] : 1'b0;
                    ST_TX: begin
                        if (scl_fall_i) sda_pd_o <= (cnt_q == TX_LAST) ? 1'b0 : ~shift_q[DW-2];
                    end
                    ST_PTR_ACK, ST_DATA_ACK, ST_TX_ACK: if (scl_fall_i) sda_pd_o <= 1'b0;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smb_ptr_target.sv
module smb_ptr_target
    import smb_tgt_pkg::*;
#(
    parameter int          FILT_CYC = 12,
    parameter logic [4:0]  ADDR_HI  = 5'b01011,
    parameter int          DW       = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic [1:0]    strap_i,
    output logic          sda_pd_o,
    output logic [DW-1:0] reg_addr_o,
    output logic [DW-1:0] reg_wdata_o,
    output logic          reg_we_o,
    input  logic [DW-1:0] reg_rdata_i
);
    localparam int NLINE = 2;
    localparam int AW    = 7;

    logic [NLINE-1:0] raw_lines;
    logic [NLINE-1:0] flt_lines;
    logic             scl_flt, sda_flt;
    logic             scl_rise, scl_fall, start_ev, stop_ev;
    logic             strap_done;
    logic [1:0]       dev_lo;
    logic [AW-1:0]    dev_addr;
    smb_state_e       fsm_state;

    assign raw_lines = {sda_i, scl_i};

    for (genvar g = 0; g < NLINE; g++) begin : g_filt
        smb_glitch_filter #(.FILT_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_lines[g]),
            .flt_o (flt_lines[g])
        );
    end

    assign scl_flt = flt_lines[0];
    assign sda_flt = flt_lines[1];

    // strap latched once after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strap_done <= 1'b0;
            dev_lo     <= 2'b00;
        end else if (!strap_done) begin
            strap_done <= 1'b1;
            dev_lo     <= strap_to_lo(strap_i);
        end
    end

    assign dev_addr = {ADDR_HI, dev_lo};

    smb_bus_events u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_f_i    (scl_flt),
        .sda_f_i    (sda_flt),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_ev),
        .stop_o     (stop_ev)
    );

    smb_target_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_ev),
        .stop_i     (stop_ev),
        .sda_f_i    (sda_flt),
        .dev_addr_i (dev_addr),
        .rdata_i    (reg_rdata_i),
        .ptr_o      (reg_addr_o),
        .wdata_o    (reg_wdata_o),
        .we_o       (reg_we_o),
        .sda_pd_o   (sda_pd_o),
        .state_o    (fsm_state)
    );
endmodule

// File: rtl/smb_ptr_target_chk.sv
module smb_ptr_target_chk
    import smb_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_f,
    input logic       start_ev,
    input logic       stop_ev,
    input smb_state_e state,
    input logic       reg_we,
    input logic       sda_pd,
    input logic       strap_done,
    input logic [1:0] dev_lo
);
    // R5: write strobe lasts one cycle
    p_we_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5: a write only follows a completed data byte
    p_we_from_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(state) == ST_DATA));

    // R8: pull-down moves only in SCL low, or on START/STOP
    p_pd_low_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pd) |-> (!scl_f || $past(start_ev) || $past(stop_ev)));

    // R3: latched address bits never change after sampling
    p_strap_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(strap_done) |-> $stable(dev_lo));

    // R10: START always restarts address decoding
    p_start_decode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));

    // R12: STOP returns to idle
    p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_ev && !start_ev) |=> (state == ST_IDLE));

    // R9: ignored traffic never sees SDA driven
    p_ignore_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE) |-> !sda_pd);
endmodule

bind smb_ptr_target smb_ptr_target_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (scl_flt),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .state      (fsm_state),
    .reg_we     (reg_we_o),
    .sda_pd     (sda_pd_o),
    .strap_done (strap_done),
    .dev_lo     (dev_lo)
);

// File: tb/tb_smb_ptr_target.sv
`timescale 1ns/1ps
module tb_smb_ptr_target;
    localparam int Q = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1, sda_gl = 1'b0;
    logic [1:0] strap = 2'b01;
    logic       sda_pd;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic       reg_we;
    logic       sda_line;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int         n_chk = 0, n_fail = 0, n_wr = 0;

    always #2.5 clk = ~clk;

    assign sda_line  = (sda_m ^ sda_gl) & ~sda_pd;
    assign reg_rdata = mem[reg_addr];

    smb_ptr_target dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .strap_i(strap), .sda_pd_o(sda_pd), .reg_addr_o(reg_addr),
        .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata)
    );

    always @(posedge clk) if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        n_wr <= n_wr + 1;
    end

    function automatic logic [6:0] exp_addr(input logic [1:0] s);
        logic [1:0] lo;
        lo = (s == 2'b00) ? 2'b10 : (s == 2'b10) ? 2'b01 : 2'b00;
        return {5'b01011, lo};
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wc(input int n); repeat (n) @(negedge clk); endtask

    task automatic do_reset(input logic [1:0] s);
        strap = s; scl_m = 1; sda_m = 1; rst_n = 0;
        wc(5); rst_n = 1; wc(Q);
    endtask

    task automatic bus_start();
        sda_m = 1; scl_m = 1; wc(Q); sda_m = 0; wc(Q); scl_m = 0; wc(Q);
    endtask

    task automatic bus_rstart();
        sda_m = 1; wc(Q); scl_m = 1; wc(Q); sda_m = 0; wc(Q); scl_m = 0; wc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wc(Q); scl_m = 1; wc(Q); sda_m = 1; wc(Q);
    endtask

    // glitch: 0 none, 1 short SCL low pulse, 2 short SDA pulse, on bit 3
    task automatic wr_byte(input logic [7:0] b, input int glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wc(Q); scl_m = 1;
            if (glitch != 0 && i == 3) begin
                wc(Q - 3);
                if (glitch == 1) scl_m = 0; else sda_gl = 1;
                wc(6);
                scl_m = 1; sda_gl = 0;
                wc(Q - 3);
            end else begin
                wc(2 * Q);
            end
            scl_m = 0; wc(Q);
        end
        sda_m = 1; wc(Q); scl_m = 1; wc(Q);
        ack = !sda_line;
        wc(Q); scl_m = 0; wc(Q);
    endtask

    task automatic rd_byte(input bit nack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1; wc(Q); scl_m = 1; wc(Q);
            b[i] = sda_line;
            wc(Q); scl_m = 0; wc(Q);
        end
        sda_m = nack; wc(Q); scl_m = 1; wc(2 * Q); scl_m = 0; wc(Q);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                             output bit a0, output bit a1, output bit a2);
        bus_start();
        wr_byte({a, 1'b0}, 0, a0);
        wr_byte(p, 0, a1);
        wr_byte(d, 0, a2);
        bus_stop();
    endtask

    task automatic ptr_then_read(input logic [6:0] a, input logic [7:0] p,
                                 output bit ok_ack, output logic [7:0] d);
        bit x, y, z;
        bus_start();
        wr_byte({a, 1'b0}, 0, x);
        wr_byte(p, 0, y);
        bus_rstart();
        wr_byte({a, 1'b1}, 0, z);
        rd_byte(1'b1, d);
        bus_stop();
        ok_ack = x && y && z;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit a0, a1, a2, ok;
        logic [7:0] d;
        int w0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end

        // reset state (R4, R12)
        do_reset(2'b01);
        chk(sda_pd == 0 && reg_we == 0, "R12 reset idle", {sda_pd, reg_we}, 0);
        chk(reg_addr == 8'h00, "R4 reset pointer", reg_addr, 0);

        // basic write (R1, R4, R5)
        w0 = n_wr;
        write_reg(7'h2C, 8'h10, 8'hA5, a0, a1, a2);
        exp_mem[8'h10] = 8'hA5;
        chk(a0, "R1 address ack", a0, 1);
        chk(a1 && reg_addr == 8'h10, "R4 pointer load", reg_addr, 8'h10);
        chk(a2 && mem[8'h10] == 8'hA5, "R5 data write", mem[8'h10], 8'hA5);
        chk(n_wr == w0 + 1, "R5 single strobe", n_wr - w0, 1);

        // third byte ignored (R6)
        w0 = n_wr;
        bus_start();
        wr_byte(8'h58, 0, a0); wr_byte(8'h20, 0, a1); wr_byte(8'h11, 0, a2);
        wr_byte(8'h22, 0, ok);
        bus_stop();
        exp_mem[8'h20] = 8'h11;
        chk(!ok, "R6 extra byte nack", ok, 0);
        chk(mem[8'h20] == 8'h11 && n_wr == w0 + 1, "R6 no extra write", mem[8'h20], 8'h11);

        // read at stored pointer (R7)
        bus_start(); wr_byte(8'h59, 0, a0); rd_byte(1'b1, d); bus_stop();
        chk(a0 && d == exp_mem[8'h20], "R7 read at pointer", d, exp_mem[8'h20]);
        chk(reg_addr == 8'h20, "R7 pointer kept", reg_addr, 8'h20);

        // mismatched address (R9)
        w0 = n_wr;
        bus_start(); wr_byte(8'h5A, 0, a0); wr_byte(8'h33, 0, a1); wr_byte(8'h44, 0, a2); bus_stop();
        chk(!a0 && !a1 && !a2, "R9 no ack on mismatch", {a0, a1, a2}, 0);
        chk(reg_addr == 8'h20 && n_wr == w0, "R9 nothing changed", reg_addr, 8'h20);

        // repeated start after mismatch (R10)
        bus_start(); wr_byte(8'h5A, 0, a0); bus_rstart(); wr_byte(8'h59, 0, a1);
        rd_byte(1'b1, d); bus_stop();
        chk(!a0 && a1 && d == exp_mem[8'h20], "R10 restart decode", d, exp_mem[8'h20]);

        // pointer-only write then repeated start read (R10)
        ptr_then_read(7'h2C, 8'h30, ok, d);
        chk(ok && d == exp_mem[8'h30], "R10 pointer across restart", d, exp_mem[8'h30]);

        // glitches (R11)
        bus_start(); wr_byte(8'h58, 0, a0); wr_byte(8'h40, 1, a1); wr_byte(8'hC3, 2, a2); bus_stop();
        exp_mem[8'h40] = 8'hC3;
        chk(a0 && a1 && a2 && mem[8'h40] == 8'hC3, "R11 glitch rejected", mem[8'h40], 8'hC3);

        // clocks without START (R12)
        wr_byte(8'h58, 0, a0); bus_stop();
        chk(!a0 && sda_pd == 0, "R12 no ack without start", a0, 0);

        // random writes and read-backs (R5, R7)
        for (int k = 0; k < 12; k++) begin
            logic [7:0] p, v;
            p = 8'($urandom); v = 8'($urandom);
            write_reg(7'h2C, p, v, a0, a1, a2);
            exp_mem[p] = v;
            chk(a0 && a1 && a2 && mem[p] == v, "R5 random write", mem[p], v);
            ptr_then_read(7'h2C, p, ok, d);
            chk(ok && d == exp_mem[p], "R7 random read", d, exp_mem[p]);
        end

        // strap changed without reset (R3)
        strap = 2'b10; wc(10);
        bus_start(); wr_byte(8'h5A, 0, a0); bus_stop();
        bus_start(); wr_byte(8'h58, 0, a1); bus_stop();
        chk(!a0 && a1, "R3 strap not resampled", {a0, a1}, 1);

        // strap levels (R2)
        do_reset(2'b00);
        bus_start(); wr_byte({exp_addr(2'b00), 1'b0}, 0, a0); bus_stop();
        bus_start(); wr_byte(8'h58, 0, a1); bus_stop();
        chk(a0 && !a1, "R2 strap low 0x2E", {a0, a1}, 2);
        do_reset(2'b10);
        bus_start(); wr_byte({exp_addr(2'b10), 1'b0}, 0, a0); bus_stop();
        chk(a0, "R2 strap high 0x2D", a0, 1);
        do_reset(2'b11);
        bus_start(); wr_byte(8'h58, 0, a0); bus_stop();
        chk(a0, "R2 code 11 as open", a0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule